// File: doc/BRIEF.md
# Zero-Turnaround Late-Write Synchronous SRAM

This block is a clocked single-port static memory. It takes a new read or write command on every rising edge and never needs an idle cycle when the traffic switches between reads and writes. The command (address, direction, byte enables, chip selects and burst advance) is sampled at the edge. The write data follows later on the same data bus, in the slot where a read issued at the same time would have returned its data. This keeps the shared bus busy on every cycle.

A static strap selects one of two timings. In pipelined timing, read data passes through an output register and is valid after the second edge. Write data is taken two edges after its command. In flow-through timing, read data is valid right after the command edge, and write data is taken one edge after its command. A second strap selects the order of four-beat bursts. An advance input then walks the two low address bits from a stored start address. A read that hits a write whose data has not been stored yet returns that data, merged byte by byte with the stored word. An output enable and a sleep input both act on the output drive without waiting for a clock.

Top module: `zt_sram`

## Requirements
- R1: A command is accepted only when cs is 3'b111. With any other cs value and adv low, the cycle is a deselect: nothing is written and no read data is driven for it.
- R2: With pipe_mode=1, a read sampled at edge e drives dout with dout_en=1 between edge e+1 and edge e+2.
- R3: With pipe_mode=1, the data of a write sampled at edge e is taken from din at edge e+2.
- R4: With pipe_mode=0, a read sampled at edge e drives dout between edge e and edge e+1, and the data of a write sampled at edge e is taken from din at edge e+1.
- R5: A read always returns the most recent write to its address, even when that write's data arrives on the same edge the read data is captured. Bytes the pending write does not enable keep the stored value.
- R6: byte_en bit i, sampled with the command, gates data bits [9i+8:9i]. Bytes that are not enabled keep their stored value.
- R7: adv=1 while a burst is open continues the burst. The upper address bits come from the burst's start address, the direction comes from the start command, and the low two bits are (start+n) mod 4 when burst_il=0 or start XOR n when burst_il=1, for beat n. The count wraps modulo 4. adv=1 when no burst is open is a deselect. A deselect or a sleep cycle closes the burst.
- R8: oe=0 forces dout_en=0 and dout=0 at once, without waiting for a clock edge.
- R9: While sleep=1, commands are ignored and treated as deselects, and dout_en=0. Write data of writes accepted before sleep still lands.
- R10: dout_en is 0 for write and deselect slots, and dout is 0 whenever dout_en is 0. Any mix of reads, writes, bursts and deselects runs at one command per clock.
- R11: After reset, no command is in flight, dout_en=0 and dout=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low; clears the command stages |
| pipe_mode | input | 1 | Static strap: 1 pipelined timing, 0 flow-through timing |
| burst_il | input | 1 | Static strap: 1 interleaved burst order, 0 linear |
| addr | input | ADDR_W | Command address |
| wr | input | 1 | Command direction: 1 write, 0 read |
| cs | input | 3 | Chip selects, all three high to accept a command |
| byte_en | input | NB | Per-byte write enables, sampled with the command |
| adv | input | 1 | Continue the open burst with its next beat |
| din | input | NB*BW | Write data from the bus |
| oe | input | 1 | Asynchronous output enable |
| sleep | input | 1 | Power-down: ignore commands, stop driving |
| dout | output | NB*BW | Read data to the bus, zero when not driven |
| dout_en | output | 1 | Bus drive enable for dout |

## Verification
The hardest case to reach is pipelined timing where a read is captured on the same edge that delivers the data of the write just before it, to the same address and with only some bytes enabled. Only then does the merge of live bus data into the output register decide the result. The bench drives back-to-back write-then-read pairs with partial byte enables to the same address in both timings and under both burst orders. It then runs a long random mix that also wraps bursts and toggles sleep and the output enable. Every output is compared each cycle with a bench memory model that applies each write at the edge where its data is due.

// File: rtl/zt_pkg.sv
package zt_pkg;

  localparam int LOW_BITS = 2;

  // Low address bits of burst beat n from the start address.
  function automatic logic [LOW_BITS-1:0] burst_low(
    input logic [LOW_BITS-1:0] start,
    input logic [LOW_BITS-1:0] beat,
    input logic                interleave
  );
    if (interleave) return start ^ beat;
    return start + beat;
  endfunction

endpackage

// File: rtl/zt_cmd_front.sv
module zt_cmd_front #(
  parameter int ADDR_W = 6,
  parameter int NB     = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              burst_il,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  input  logic [2:0]        cs,
  input  logic [NB-1:0]     byte_en,
  input  logic              adv,
  input  logic              sleep,
  output logic              s1_vld,
  output logic              s1_wr,
  output logic [ADDR_W-1:0] s1_addr,
  output logic [NB-1:0]     s1_be,
  output logic              burst_live
);
  localparam int LB = zt_pkg::LOW_BITS;

  logic [ADDR_W-1:0] base_q;
  logic [LB-1:0]     cnt_q;
  logic              bwr_q;

  logic          take_new;
  logic          take_adv;
  logic [LB-1:0] cnt_nxt;

  assign take_new = !sleep && !adv && (&cs);
  assign take_adv = !sleep && adv && burst_live;
  assign cnt_nxt  = cnt_q + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_vld     <= 1'b0;
      s1_wr      <= 1'b0;
      s1_addr    <= '0;
      s1_be      <= '0;
      base_q     <= '0;
      cnt_q      <= '0;
      bwr_q      <= 1'b0;
      burst_live <= 1'b0;
    end else begin
      s1_be <= byte_en;
      if (take_new) begin
        s1_vld     <= 1'b1;
        s1_wr      <= wr;
        s1_addr    <= addr;
        base_q     <= addr;
        cnt_q      <= '0;
        bwr_q      <= wr;
        burst_live <= 1'b1;
      end else if (take_adv) begin
        s1_vld  <= 1'b1;
        s1_wr   <= bwr_q;
        s1_addr <= {base_q[ADDR_W-1:LB],
                    zt_pkg::burst_low(base_q[LB-1:0], cnt_nxt, burst_il)};
        cnt_q   <= cnt_nxt;
      end else begin
        s1_vld     <= 1'b0;
        s1_wr      <= 1'b0;
        burst_live <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/zt_store.sv
module zt_store #(
  parameter int ADDR_W = 6,
  parameter int NB     = 4,
  parameter int BW     = 9
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [NB-1:0]     wr_be,
  input  logic [NB*BW-1:0]  wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [NB*BW-1:0]  rd_data
);
  localparam int DEPTH  = 1 << ADDR_W;
  localparam int DATA_W = NB * BW;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    for (int i = 0; i < NB; i++) begin
      if (wr_en && wr_be[i]) mem[wr_addr][i*BW +: BW] <= wr_data[i*BW +: BW];
    end
  end

  assign rd_data = mem[rd_addr];

endmodule

// File: rtl/zt_out_path.sv
module zt_out_path #(
  parameter int NB = 4,
  parameter int BW = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pipe_mode,
  input  logic             s1_rd,
  input  logic [NB*BW-1:0] rd_data,
  input  logic             byp_hit,
  input  logic [NB-1:0]    byp_be,
  input  logic [NB*BW-1:0] din,
  input  logic             oe,
  input  logic             sleep,
  output logic [NB*BW-1:0] dout,
  output logic             dout_en,
  output logic             rd_v_q
);
  localparam int DATA_W = NB * BW;

  logic [DATA_W-1:0] merged;
  logic [DATA_W-1:0] dq;
  logic [DATA_W-1:0] data_sel;
  logic              rd_live;

  for (genvar g = 0; g < NB; g++) begin : g_merge
    assign merged[g*BW +: BW] = (byp_hit && byp_be[g]) ? din[g*BW +: BW]
                                                       : rd_data[g*BW +: BW];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dq     <= '0;
      rd_v_q <= 1'b0;
    end else begin
      dq     <= merged;
      rd_v_q <= s1_rd;
    end
  end

  assign data_sel = pipe_mode ? dq : rd_data;
  assign rd_live  = pipe_mode ? rd_v_q : s1_rd;
  assign dout_en  = oe && !sleep && rd_live;
  assign dout     = dout_en ? data_sel : '0;

endmodule

// File: rtl/zt_sram.sv
module zt_sram #(
  parameter int ADDR_W = 6,
  parameter int NB     = 4,
  parameter int BW     = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pipe_mode,
  input  logic              burst_il,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  input  logic [2:0]        cs,
  input  logic [NB-1:0]     byte_en,
  input  logic              adv,
  input  logic [NB*BW-1:0]  din,
  input  logic              oe,
  input  logic              sleep,
  output logic [NB*BW-1:0]  dout,
  output logic              dout_en
);
  localparam int DATA_W = NB * BW;

  // First command stage and burst state
  logic              s1_vld, s1_wr, burst_live;
  logic [ADDR_W-1:0] s1_addr;
  logic [NB-1:0]     s1_be;

  // Second command stage, used by pipelined timing
  logic              s2_vld, s2_wr;
  logic [ADDR_W-1:0] s2_addr;
  logic [NB-1:0]     s2_be;

  // Named internal events
  logic              s1_rd;
  logic              commit_we;
  logic [ADDR_W-1:0] commit_addr;
  logic [NB-1:0]     commit_be;
  logic              byp_hit;
  logic              rd_v_q;
  logic [DATA_W-1:0] rd_data;

  zt_cmd_front #(.ADDR_W(ADDR_W), .NB(NB)) u_front (
    .clk        (clk),
    .rst_n      (rst_n),
    .burst_il   (burst_il),
    .addr       (addr),
    .wr         (wr),
    .cs         (cs),
    .byte_en    (byte_en),
    .adv        (adv),
    .sleep      (sleep),
    .s1_vld     (s1_vld),
    .s1_wr      (s1_wr),
    .s1_addr    (s1_addr),
    .s1_be      (s1_be),
    .burst_live (burst_live)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s2_vld  <= 1'b0;
      s2_wr   <= 1'b0;
      s2_addr <= '0;
      s2_be   <= '0;
    end else begin
      s2_vld  <= s1_vld;
      s2_wr   <= s1_wr;
      s2_addr <= s1_addr;
      s2_be   <= s1_be;
    end
  end

  // Late write: one stage back in flow-through, two in pipelined timing
  assign s1_rd       = s1_vld && !s1_wr;
  assign commit_we   = pipe_mode ? (s2_vld && s2_wr) : (s1_vld && s1_wr);
  assign commit_addr = pipe_mode ? s2_addr : s1_addr;
  assign commit_be   = pipe_mode ? s2_be : s1_be;

  // Read captured on the edge that lands the previous write's data
  assign byp_hit = pipe_mode && s2_vld && s2_wr && s1_rd && (s2_addr == s1_addr);

  zt_store #(.ADDR_W(ADDR_W), .NB(NB), .BW(BW)) u_store (
    .clk     (clk),
    .wr_en   (commit_we),
    .wr_addr (commit_addr),
    .wr_be   (commit_be),
    .wr_data (din),
    .rd_addr (s1_addr),
    .rd_data (rd_data)
  );

  zt_out_path #(.NB(NB), .BW(BW)) u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .pipe_mode (pipe_mode),
    .s1_rd     (s1_rd),
    .rd_data   (rd_data),
    .byp_hit   (byp_hit),
    .byp_be    (s2_be),
    .din       (din),
    .oe        (oe),
    .sleep     (sleep),
    .dout      (dout),
    .dout_en   (dout_en),
    .rd_v_q    (rd_v_q)
  );

endmodule

// File: rtl/zt_sram_chk.sv
module zt_sram_chk #(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 36
) (
  input logic              clk,
  input logic              rst_n,
  input logic              pipe_mode,
  input logic [2:0]        cs,
  input logic              adv,
  input logic              oe,
  input logic              sleep,
  input logic              s1_vld,
  input logic              s1_wr,
  input logic [ADDR_W-1:0] s1_addr,
  input logic              burst_live,
  input logic              commit_we,
  input logic              dout_en,
  input logic [DATA_W-1:0] dout
);

  a_r1_deselect: assert property (@(posedge clk) disable iff (!rst_n)
    (!sleep && !adv && !(&cs)) |=> !s1_vld);

  a_r9_sleep_ignores: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |=> !s1_vld);

  a_r8_oe_off: assert property (@(posedge clk) disable iff (!rst_n)
    !oe |-> (!dout_en && dout == '0));

  a_r2_pipe_latency: assert property (@(posedge clk) disable iff (!rst_n)
    (pipe_mode && dout_en) |-> $past(s1_vld && !s1_wr));

  a_r3_commit_source: assert property (@(posedge clk) disable iff (!rst_n)
    (pipe_mode && commit_we) |-> $past(s1_vld && s1_wr));

  a_r10_no_drive_on_write: assert property (@(posedge clk) disable iff (!rst_n)
    (!pipe_mode && s1_vld && s1_wr) |-> !dout_en);

  a_r7_burst_upper: assert property (@(posedge clk) disable iff (!rst_n)
    (!sleep && adv && burst_live) |=>
      (s1_vld && s1_addr[ADDR_W-1:2] == $past(s1_addr[ADDR_W-1:2])));

endmodule

bind zt_sram zt_sram_chk #(.ADDR_W(ADDR_W), .DATA_W(NB*BW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .pipe_mode  (pipe_mode),
  .cs         (cs),
  .adv        (adv),
  .oe         (oe),
  .sleep      (sleep),
  .s1_vld     (s1_vld),
  .s1_wr      (s1_wr),
  .s1_addr    (s1_addr),
  .burst_live (burst_live),
  .commit_we  (commit_we),
  .dout_en    (dout_en),
  .dout       (dout)
);

// File: tb/tb_zt_sram.sv
module tb_zt_sram;
  localparam int AW = 6;
  localparam int NB = 4;
  localparam int BW = 9;
  localparam int DW = NB * BW;
  localparam int DEPTH = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          pipe_mode = 1'b1;
  logic          burst_il = 1'b0;
  logic [AW-1:0] addr = '0;
  logic          wr = 1'b0;
  logic [2:0]    cs = 3'b000;
  logic [NB-1:0] byte_en = '0;
  logic          adv = 1'b0;
  logic [DW-1:0] din = '0;
  logic          oe = 1'b1;
  logic          sleep = 1'b0;
  logic [DW-1:0] dout;
  logic          dout_en;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  zt_sram #(.ADDR_W(AW), .NB(NB), .BW(BW)) dut (
    .clk(clk), .rst_n(rst_n), .pipe_mode(pipe_mode), .burst_il(burst_il),
    .addr(addr), .wr(wr), .cs(cs), .byte_en(byte_en), .adv(adv),
    .din(din), .oe(oe), .sleep(sleep), .dout(dout), .dout_en(dout_en)
  );

  // Reference model
  logic [DW-1:0] mem [DEPTH];
  logic          h_v [4];
  logic          h_w [4];
  logic [AW-1:0] h_a [4];
  logic [NB-1:0] h_b [4];
  int            ecyc;
  logic          m_live, m_bwr;
  logic [AW-1:0] m_base;
  logic [1:0]    m_cnt;
  logic          exp_en;
  logic [DW-1:0] exp_dout;

  task automatic model_edge();
    logic v, w;
    logic [AW-1:0] a;
    int slot, ci, ri, lat;
    v = 1'b0; w = 1'b0; a = '0;
    if (sleep) m_live = 1'b0;
    else if (adv) begin
      if (m_live) begin
        m_cnt = m_cnt + 2'd1;
        v = 1'b1;
        w = m_bwr;
        if (burst_il) a = {m_base[AW-1:2], m_base[1:0] ^ m_cnt};
        else          a = {m_base[AW-1:2], 2'(m_base[1:0] + m_cnt)};
      end
    end else if (cs == 3'b111) begin
      v = 1'b1; w = wr; a = addr;
      m_base = addr; m_cnt = 2'd0; m_live = 1'b1; m_bwr = wr;
    end else m_live = 1'b0;
    slot = ecyc & 3;
    h_v[slot] = v; h_w[slot] = w; h_a[slot] = a; h_b[slot] = byte_en;
    lat = pipe_mode ? 2 : 1;
    ci = (ecyc - lat) & 3;
    if (h_v[ci] && h_w[ci]) begin
      for (int k = 0; k < NB; k++)
        if (h_b[ci][k]) mem[h_a[ci]][k*BW +: BW] = din[k*BW +: BW];
    end
    ri = pipe_mode ? ((ecyc - 1) & 3) : slot;
    exp_en = oe && !sleep && h_v[ri] && !h_w[ri];
    exp_dout = exp_en ? mem[h_a[ri]] : '0;
    ecyc++;
  endtask

  task automatic check(input string tag);
    checks++;
    if (dout_en !== exp_en || dout !== exp_dout) begin
      errors++;
      $display("FAIL %s: actual en=%0b dout=%h expected en=%0b dout=%h",
               tag, dout_en, dout, exp_en, exp_dout);
    end
  endtask

  // One clock: drive at the falling edge, model at the rising edge, check after it
  task automatic cyc(input logic [AW-1:0] a, input logic w, input logic [2:0] c,
                     input logic [NB-1:0] b, input logic ad, input logic o,
                     input logic s, input string tag);
    addr = a; wr = w; cs = c; byte_en = b; adv = ad; oe = o; sleep = s;
    din = {4'($urandom()), 32'($urandom())};
    @(posedge clk);
    model_edge();
    #5;
    check(tag);
    @(negedge clk);
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) cyc('0, 1'b0, 3'b000, '0, 1'b0, 1'b1, 1'b0, tag);
  endtask

  task automatic do_reset(input logic pm, input logic il);
    @(negedge clk);
    rst_n = 1'b0; pipe_mode = pm; burst_il = il;
    cs = 3'b000; adv = 1'b0; sleep = 1'b0; oe = 1'b1; wr = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < 4; i++) h_v[i] = 1'b0;
    ecyc = 0; m_live = 1'b0; m_cnt = '0; m_base = '0; m_bwr = 1'b0;
    #1;
    checks++;
    if (dout_en !== 1'b0 || dout !== '0) begin
      errors++;
      $display("FAIL R11: actual en=%0b dout=%h expected en=0 dout=0", dout_en, dout);
    end
  endtask

  task automatic run_config(input logic pm, input logic il);
    string tl;
    tl = pm ? "R3" : "R4";
    do_reset(pm, il);
    idle(1, "R11");
    // Fill every word, then read it back
    for (int a = 0; a < DEPTH; a++) cyc(AW'(a), 1'b1, 3'b111, '1, 1'b0, 1'b1, 1'b0, tl);
    idle(2, tl);
    for (int a = 0; a < DEPTH; a++)
      cyc(AW'(a), 1'b0, 3'b111, '1, 1'b0, 1'b1, 1'b0, pm ? "R2" : "R4");
    idle(2, "R2");
    // Byte enables, every pattern on one word
    for (int b = 0; b < 16; b++) begin
      cyc(AW'(9), 1'b1, 3'b111, NB'(b), 1'b0, 1'b1, 1'b0, "R6");
      idle(2, "R6");
      cyc(AW'(9), 1'b0, 3'b111, '0, 1'b0, 1'b1, 1'b0, "R6");
      idle(2, "R6");
    end
    // Write immediately followed by read of the same word, partial bytes
    for (int b = 0; b < 16; b++) begin
      cyc(AW'(20 + (b & 3)), 1'b1, 3'b111, NB'(b), 1'b0, 1'b1, 1'b0, "R5");
      cyc(AW'(20 + (b & 3)), 1'b0, 3'b111, '0, 1'b0, 1'b1, 1'b0, "R5");
      cyc(AW'(20 + (b & 3)), 1'b1, 3'b111, NB'(~b), 1'b0, 1'b1, 1'b0, "R5");
      cyc(AW'(33), 1'b1, 3'b111, '1, 1'b0, 1'b1, 1'b0, "R5");
      cyc(AW'(20 + (b & 3)), 1'b0, 3'b111, '0, 1'b0, 1'b1, 1'b0, "R5");
    end
    idle(2, "R5");
    // Bursts from every start, both directions, wrapping past four beats
    for (int s = 0; s < 4; s++) begin
      cyc(AW'(40 + s), 1'b1, 3'b111, '1, 1'b0, 1'b1, 1'b0, "R7");
      for (int n = 0; n < 5; n++)
        cyc(AW'($urandom()), 1'b0, 3'($urandom()), '1, 1'b1, 1'b1, 1'b0, "R7");
      cyc(AW'(40 + s), 1'b0, 3'b111, '1, 1'b0, 1'b1, 1'b0, "R7");
      for (int n = 0; n < 5; n++)
        cyc(AW'($urandom()), 1'b1, 3'($urandom()), '1, 1'b1, 1'b1, 1'b0, "R7");
      idle(1, "R7");
      cyc(AW'(40 + s), 1'b1, 3'b111, '1, 1'b1, 1'b1, 1'b0, "R7");
      idle(2, "R7");
    end
    for (int a = 40; a < 44; a++) cyc(AW'(a), 1'b0, 3'b111, '0, 1'b0, 1'b1, 1'b0, "R7");
    idle(2, "R7");
    // Partial chip selects must not write or read
    for (int c = 0; c < 7; c++) begin
      cyc(AW'(50), 1'b1, 3'(c), '1, 1'b0, 1'b1, 1'b0, "R1");
      cyc(AW'(50), 1'b0, 3'(c), '0, 1'b0, 1'b1, 1'b0, "R1");
      idle(2, "R1");
      cyc(AW'(50), 1'b0, 3'b111, '0, 1'b0, 1'b1, 1'b0, "R1");
      idle(2, "R1");
    end
    // Output enable low hides read data
    cyc(AW'(3), 1'b0, 3'b111, '0, 1'b0, 1'b0, 1'b0, "R8");
    cyc(AW'(4), 1'b0, 3'b111, '0, 1'b0, 1'b0, 1'b0, "R8");
    cyc(AW'(5), 1'b0, 3'b111, '0, 1'b0, 1'b1, 1'b0, "R8");
    cyc(AW'(6), 1'b0, 3'b111, '0, 1'b0, 1'b0, 1'b0, "R8");
    idle(2, "R8");
    // Sleep ignores commands and stops driving
    cyc(AW'(7), 1'b1, 3'b111, '1, 1'b0, 1'b1, 1'b1, "R9");
    cyc(AW'(7), 1'b0, 3'b111, '0, 1'b0, 1'b1, 1'b1, "R9");
    cyc(AW'(8), 1'b1, 3'b111, '1, 1'b0, 1'b1, 1'b0, "R9");
    cyc(AW'(8), 1'b0, 3'b111, '0, 1'b1, 1'b1, 1'b1, "R9");
    cyc(AW'(8), 1'b0, 3'b111, '0, 1'b1, 1'b1, 1'b1, "R9");
    idle(2, "R9");
    cyc(AW'(7), 1'b0, 3'b111, '0, 1'b0, 1'b1, 1'b0, "R9");
    cyc(AW'(8), 1'b0, 3'b111, '0, 1'b0, 1'b1, 1'b0, "R9");
    idle(2, "R9");
    // Random mix at full rate
    for (int i = 0; i < 600; i++) begin
      logic [2:0] c;
      c = ($urandom_range(0, 9) < 8) ? 3'b111 : 3'($urandom());
      cyc(AW'($urandom()), 1'($urandom()), c, NB'($urandom()),
          $urandom_range(0, 3) == 0, $urandom_range(0, 9) != 0,
          $urandom_range(0, 19) == 0, "R10");
    end
    idle(3, "R10");
  endtask

  initial begin
    for (int a = 0; a < DEPTH; a++) mem[a] = '0;
    for (int i = 0; i < 4; i++) begin
      h_v[i] = 1'b0; h_w[i] = 1'b0; h_a[i] = '0; h_b[i] = '0;
    end
    ecyc = 0; m_live = 1'b0; m_bwr = 1'b0; m_base = '0; m_cnt = '0;
    exp_en = 1'b0; exp_dout = '0;
    run_config(1'b1, 1'b0);
    run_config(1'b1, 1'b1);
    run_config(1'b0, 1'b0);
    run_config(1'b0, 1'b1);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog (all requirements): actual run past %0d cycles, expected completion",
               150000);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule